// File: doc/BRIEF.md
# Coupling-Aware Bus Transition Energy Monitor

This block sits beside an on-chip parallel bus and estimates the switching energy that the bus wires draw. Each time the sample strobe is high, it compares the presented word with the word seen at the previous strobe. It reports two figures for that step. The first is the number of lines that changed. The second is a weighted energy figure. In that figure, every changed line costs a ground weight. Every pair of neighbouring lines in which at least one line moved costs a side weight times a direction-dependent coupling factor.

The coupling factor models the effective side capacitance between two adjacent wires. Two wires that move in opposite directions see that capacitance doubled, so the factor is 2. Two wires that move together see none of it, so the factor is 0. A moving wire beside a quiet one sees it once, so the factor is 1. Lines further apart than one position are not coupled. Both figures also feed two saturating totals, which a clear input resets and a freeze input holds.

A small controller has two states. MON_EMPTY means there is no reference word yet. MON_PRIMED means a reference word is held. The transition LOAD goes from MON_EMPTY to MON_PRIMED on a strobe. SCORE is the self-loop in MON_PRIMED on each strobe. FLUSH returns to MON_EMPTY from either state on a clear.

Top module: `bus_xition_energy_mon`

## Requirements
- R1: While reset is asserted and at the first sample after it, the state is MON_EMPTY, `res_vld` is 0, and `res_flips`, `res_energy`, `tot_flips` and `tot_energy` are all 0.
- R2: For each scored strobe, `res_flips` equals the Hamming distance between the new word and the stored word. For example, 16'h0000 followed by 16'h000F gives 4.
- R3: An adjacent pair whose lines move in opposite directions (one 0 to 1, the other 1 to 0) adds a coupling factor of 2.
- R4: An adjacent pair whose lines both move in the same direction adds a coupling factor of 0.
- R5: An adjacent pair with exactly one moving line adds a factor of 1. A pair with no moving line adds 0. Bit 0 and bit BUS_W-1 each belong to only one pair, so they are coupled on one side only.
- R6: `res_energy` = `gnd_wgt` × flips + `side_wgt` × (sum of the pair factors over the BUS_W-1 adjacent pairs).
- R7: The first strobe after reset or after a clear only stores the word. `res_vld` stays 0 on the next cycle, and the totals do not change.
- R8: For a strobe in MON_PRIMED, `res_vld` is 1 on the following clock cycle and the new results are visible then. In every other cycle `res_vld` is 0, and `res_flips`/`res_energy` keep their last values.
- R9: On each scored strobe without freeze, `tot_flips` and `tot_energy` grow by the reported values in the same cycle in which those values appear. Each total stops at all ones instead of wrapping.
- R10: While `tot_freeze` is 1, the totals hold their value. Words are still stored, and per-step results are still produced.
- R11: A clear zeroes both totals and returns to MON_EMPTY on the next edge. It also drops `res_vld`. It takes priority over a strobe in the same cycle, and that strobe's word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Sample strobe for `bus_word` |
| bus_word | input | BUS_W | Observed bus value |
| gnd_wgt | input | WGT_W | Energy units per changed line |
| side_wgt | input | WGT_W | Energy units per unit of coupling factor |
| tot_clr | input | 1 | Zero totals and forget the stored word |
| tot_freeze | input | 1 | Hold the totals |
| res_vld | output | 1 | Per-step results are new this cycle |
| res_flips | output | CNT_W | Changed-line count of the last scored step |
| res_energy | output | EN_W | Weighted energy of the last scored step |
| tot_flips | output | ACC_W | Saturating total of changed lines |
| tot_energy | output | ACC_W | Saturating total of weighted energy |

## Verification
Each result is due one clock edge after the strobe that causes it. This holds for the per-step figures, `res_vld` and both totals. A clear takes effect on that same next edge. The bench drives every input on the falling edge. Before that edge it advances a behavioural model by exactly one step. It then compares every output against the model at the next falling edge, so each comparison falls half a period after the edge where the design registered the value. Directed checks at the same points pin down the coupling factors, the load-only first sample, freeze, clear priority and saturation.

// File: rtl/xmon_pkg.sv
package xmon_pkg;
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_RISE = 2'd1,
        DIR_FALL = 2'd2
    } line_dir_t;

    typedef enum logic {
        MON_EMPTY  = 1'b0,
        MON_PRIMED = 1'b1
    } mon_state_t;

    function automatic logic [1:0] pair_factor(input line_dir_t a, input line_dir_t b);
        logic [1:0] f;
        if (a == DIR_HOLD && b == DIR_HOLD)      f = 2'd0;
        else if (a == DIR_HOLD || b == DIR_HOLD) f = 2'd1;
        else if (a == b)                         f = 2'd0;
        else                                     f = 2'd2;
        return f;
    endfunction
endpackage

// File: rtl/xmon_line_classify.sv
module xmon_line_classify
    import xmon_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic [BUS_W-1:0]      prev_word,
    input  logic [BUS_W-1:0]      cur_word,
    output logic [BUS_W-1:0]      moved,
    output logic [BUS_W-2:0][1:0] pair_fac
);
    line_dir_t dir [BUS_W];

    for (genvar i = 0; i < BUS_W; i++) begin : g_line
        always_comb begin
            unique case ({prev_word[i], cur_word[i]})
                2'b01:   dir[i] = DIR_RISE;
                2'b10:   dir[i] = DIR_FALL;
                default: dir[i] = DIR_HOLD;
            endcase
            moved[i] = (dir[i] != DIR_HOLD);
        end
    end

    for (genvar p = 0; p < BUS_W - 1; p++) begin : g_pair
        always_comb pair_fac[p] = pair_factor(dir[p], dir[p+1]);
    end
endmodule

// File: rtl/xmon_energy_calc.sv
module xmon_energy_calc #(
    parameter int BUS_W  = 16,
    parameter int WGT_W  = 8,
    parameter int CNT_W  = 5,
    parameter int CSUM_W = 5,
    parameter int EN_W   = 14
) (
    input  logic [BUS_W-1:0]      moved,
    input  logic [BUS_W-2:0][1:0] pair_fac,
    input  logic [WGT_W-1:0]      gnd_wgt,
    input  logic [WGT_W-1:0]      side_wgt,
    output logic [CNT_W-1:0]      flips,
    output logic [EN_W-1:0]       energy
);
    logic [CSUM_W-1:0] csum;

    always_comb begin
        flips = '0;
        for (int i = 0; i < BUS_W; i++)
            flips = flips + CNT_W'(moved[i]);
    end

    always_comb begin
        csum = '0;
        for (int p = 0; p < BUS_W - 1; p++)
            csum = csum + CSUM_W'(pair_fac[p]);
    end

    always_comb
        energy = EN_W'(gnd_wgt) * EN_W'(flips) + EN_W'(side_wgt) * EN_W'(csum);
endmodule

// File: rtl/xmon_sat_total.sv
module xmon_sat_total #(
    parameter int IN_W  = 14,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero,
    input  logic             add_en,
    input  logic [IN_W-1:0]  inc,
    output logic [ACC_W-1:0] total
);
    logic [ACC_W:0] sum;

    always_comb sum = {1'b0, total} + (ACC_W+1)'(inc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                total <= '0;
        else if (zero)             total <= '0;
        else if (add_en) begin
            if (sum[ACC_W])        total <= '1;
            else                   total <= sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/bus_xition_energy_mon.sv
module bus_xition_energy_mon
    import xmon_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int WGT_W  = 8,
    parameter int ACC_W  = 32,
    localparam int CNT_W  = $clog2(BUS_W + 1),
    localparam int CSUM_W = $clog2(2 * BUS_W),
    localparam int EN_W   = WGT_W + CSUM_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [BUS_W-1:0] bus_word,
    input  logic [WGT_W-1:0] gnd_wgt,
    input  logic [WGT_W-1:0] side_wgt,
    input  logic             tot_clr,
    input  logic             tot_freeze,
    output logic             res_vld,
    output logic [CNT_W-1:0] res_flips,
    output logic [EN_W-1:0]  res_energy,
    output logic [ACC_W-1:0] tot_flips,
    output logic [ACC_W-1:0] tot_energy
);
    mon_state_t state_q, state_d;
    logic [BUS_W-1:0]      prev_q;
    logic [BUS_W-1:0]      moved;
    logic [BUS_W-2:0][1:0] pair_fac;
    logic [CNT_W-1:0]      step_flips;
    logic [EN_W-1:0]       step_energy;
    logic take, score;

    initial begin
        if (BUS_W < 2)  $error("BUS_W must be at least 2");
        if (EN_W > ACC_W) $error("ACC_W too narrow for one step");
    end

    xmon_line_classify #(.BUS_W(BUS_W)) u_cls (
        .prev_word (prev_q),
        .cur_word  (bus_word),
        .moved     (moved),
        .pair_fac  (pair_fac)
    );

    xmon_energy_calc #(
        .BUS_W(BUS_W), .WGT_W(WGT_W), .CNT_W(CNT_W),
        .CSUM_W(CSUM_W), .EN_W(EN_W)
    ) u_calc (
        .moved    (moved),
        .pair_fac (pair_fac),
        .gnd_wgt  (gnd_wgt),
        .side_wgt (side_wgt),
        .flips    (step_flips),
        .energy   (step_energy)
    );

    // strobe accepted only when no clear competes with it
    always_comb take  = smp_vld && !tot_clr;
    always_comb score = take && (state_q == MON_PRIMED);

    // next-state: LOAD, SCORE, FLUSH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_EMPTY:  if (take) state_d = MON_PRIMED;
            MON_PRIMED: state_d = MON_PRIMED;
            default:    state_d = MON_EMPTY;
        endcase
        if (tot_clr) state_d = MON_EMPTY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MON_EMPTY;
        else        state_q <= state_d;
    end

    // datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q     <= '0;
            res_vld    <= 1'b0;
            res_flips  <= '0;
            res_energy <= '0;
        end else begin
            if (take) prev_q <= bus_word;
            res_vld <= score;
            if (score) begin
                res_flips  <= step_flips;
                res_energy <= step_energy;
            end
        end
    end

    localparam int NTOT = 2;
    logic [NTOT-1:0][EN_W-1:0]  tot_inc;
    logic [NTOT-1:0][ACC_W-1:0] tot_val;

    always_comb begin
        tot_inc[0] = EN_W'(step_flips);
        tot_inc[1] = step_energy;
    end

    for (genvar k = 0; k < NTOT; k++) begin : g_tot
        xmon_sat_total #(.IN_W(EN_W), .ACC_W(ACC_W)) u_tot (
            .clk    (clk),
            .rst_n  (rst_n),
            .zero   (tot_clr),
            .add_en (score && !tot_freeze),
            .inc    (tot_inc[k]),
            .total  (tot_val[k])
        );
    end

    always_comb begin
        tot_flips  = tot_val[0];
        tot_energy = tot_val[1];
    end
endmodule

// File: rtl/xmon_checker.sv
module xmon_checker #(
    parameter int BUS_W = 16,
    parameter int WGT_W = 8,
    parameter int ACC_W = 32,
    localparam int CNT_W  = $clog2(BUS_W + 1),
    localparam int CSUM_W = $clog2(2 * BUS_W),
    localparam int EN_W   = WGT_W + CSUM_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_vld,
    input logic             tot_clr,
    input logic             tot_freeze,
    input logic             res_vld,
    input logic [CNT_W-1:0] res_flips,
    input logic [EN_W-1:0]  res_energy,
    input logic [ACC_W-1:0] tot_flips,
    input logic [ACC_W-1:0] tot_energy
);
    AST_VLD_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(smp_vld) && !$past(tot_clr)); // R8
    AST_FLIPS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        res_flips <= CNT_W'(BUS_W)); // R2
    AST_QUIET_STEP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_flips == '0) |-> res_energy == '0); // R6
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        tot_clr |=> (tot_flips == '0 && tot_energy == '0 && !res_vld)); // R11
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tot_freeze && !tot_clr) |=> ($stable(tot_flips) && $stable(tot_energy))); // R10
    AST_NO_WRAP_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        !tot_clr |=> tot_flips >= $past(tot_flips)); // R9
    AST_NO_WRAP_ENERGY: assert property (@(posedge clk) disable iff (!rst_n)
        !tot_clr |=> tot_energy >= $past(tot_energy)); // R9
endmodule

bind bus_xition_energy_mon xmon_checker #(
    .BUS_W(BUS_W), .WGT_W(WGT_W), .ACC_W(ACC_W)
) u_xmon_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_vld    (smp_vld),
    .tot_clr    (tot_clr),
    .tot_freeze (tot_freeze),
    .res_vld    (res_vld),
    .res_flips  (res_flips),
    .res_energy (res_energy),
    .tot_flips  (tot_flips),
    .tot_energy (tot_energy)
);

// File: tb/sim_bus_xition_energy_mon.sv
module sim_bus_xition_energy_mon;
    localparam int BUS_W = 16;
    localparam int WGT_W = 8;
    localparam int ACC_W = 16;
    localparam int CNT_W = $clog2(BUS_W + 1);
    localparam int EN_W  = WGT_W + $clog2(2 * BUS_W) + 1;
    localparam longint TOT_MAX = (longint'(1) << ACC_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic [BUS_W-1:0] bus_word = '0;
    logic [WGT_W-1:0] gnd_wgt = '0;
    logic [WGT_W-1:0] side_wgt = '0;
    logic tot_clr = 1'b0;
    logic tot_freeze = 1'b0;
    logic res_vld;
    logic [CNT_W-1:0] res_flips;
    logic [EN_W-1:0]  res_energy;
    logic [ACC_W-1:0] tot_flips, tot_energy;

    always #10 clk = ~clk;

    bus_xition_energy_mon #(.BUS_W(BUS_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .bus_word(bus_word),
        .gnd_wgt(gnd_wgt), .side_wgt(side_wgt), .tot_clr(tot_clr),
        .tot_freeze(tot_freeze), .res_vld(res_vld), .res_flips(res_flips),
        .res_energy(res_energy), .tot_flips(tot_flips), .tot_energy(tot_energy)
    );

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // behavioural model state
    bit     m_have;
    int     m_prev;
    bit     m_vld;
    longint m_flips, m_energy, m_tf, m_te;

    task automatic chk(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int dirof(input int p, input int c, input int i);
        int a = (p >> i) & 1;
        int b = (c >> i) & 1;
        if (a == b) return 0;
        return (b == 1) ? 1 : -1;
    endfunction

    function automatic longint coupling(input int p, input int c);
        longint s = 0;
        for (int i = 0; i < BUS_W - 1; i++) begin
            int d = dirof(p, c, i) - dirof(p, c, i + 1);
            s += (d < 0) ? -d : d;
        end
        return s;
    endfunction

    function automatic longint hamming(input int p, input int c);
        longint s = 0;
        for (int i = 0; i < BUS_W; i++) s += ((p ^ c) >> i) & 1;
        return s;
    endfunction

    function automatic longint satadd(input longint a, input longint b);
        return (a + b > TOT_MAX) ? TOT_MAX : a + b;
    endfunction

    task automatic model_step(input bit v, input int w, input bit clr, input bit frz);
        if (clr) begin
            m_have = 0; m_vld = 0; m_tf = 0; m_te = 0;
        end else begin
            m_vld = v && m_have;
            if (m_vld) begin
                m_flips  = hamming(m_prev, w);
                m_energy = longint'(gnd_wgt) * m_flips + longint'(side_wgt) * coupling(m_prev, w);
                if (!frz) begin
                    m_tf = satadd(m_tf, m_flips);
                    m_te = satadd(m_te, m_energy);
                end
            end
            if (v) begin m_have = 1; m_prev = w; end
        end
    endtask

    task automatic compare_all();
        chk("R8 res_vld", res_vld, m_vld);
        chk("R2 res_flips", res_flips, m_flips);
        chk("R6 res_energy", res_energy, m_energy);
        chk("R9 tot_flips", tot_flips, m_tf);
        chk("R9 tot_energy", tot_energy, m_te);
    endtask

    task automatic step(input bit v, input int w, input bit clr, input bit frz);
        smp_vld = v; bus_word = BUS_W'(w); tot_clr = clr; tot_freeze = frz;
        model_step(v, w, clr, frz);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        longint te0, tf0;
        m_have = 0; m_prev = 0; m_vld = 0; m_flips = 0; m_energy = 0; m_tf = 0; m_te = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 res_vld", res_vld, 0);
        chk("R1 tot_energy", tot_energy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        // pure coupling figure: g=0, s=1
        gnd_wgt = 0; side_wgt = 1;
        step(1, 16'h0000, 0, 0);
        chk("R7 first sample load only", res_vld, 0);
        chk("R7 totals untouched", tot_energy, 0);
        step(1, 16'h000F, 0, 0);        // low nibble rises together
        chk("R2 hamming 4", res_flips, 4);
        chk("R4 same dir pairs 0, R5 edge pair 1", res_energy, 1);
        step(1, 16'h000E, 0, 0);        // bit0 falls alone, one neighbour
        chk("R5 edge line one side", res_energy, 1);
        step(1, 16'h000D, 0, 0);        // bit0 rises, bit1 falls
        chk("R3 opposite pair", res_energy, 2 + 1 + 0);
        step(1, 16'h8000 | 16'h000D, 0, 0); // MSB alone
        chk("R5 top edge line", res_energy, 1);
        step(0, 16'hFFFF, 0, 0);
        chk("R8 no strobe no valid", res_vld, 0);
        chk("R8 results hold", res_energy, 1);

        // R6 weighted mix
        gnd_wgt = 3; side_wgt = 5;
        step(1, 16'h5555, 0, 0);
        step(1, 16'hAAAA, 0, 0);
        chk("R6 alternating flip", res_energy, 3 * 16 + 5 * 30);
        for (int k = 0; k < 20; k++) step(1, (k * 16'h3A5B + 16'h1111) & 16'hFFFF, 0, 0);

        // R10 freeze
        tf0 = tot_flips; te0 = tot_energy;
        step(1, 16'h00FF, 0, 1);
        step(1, 16'hFF00, 0, 1);
        chk("R10 frozen energy", tot_energy, te0);
        chk("R10 frozen flips", tot_flips, tf0);
        chk("R10 results still valid", res_vld, 1);

        // R11 clear beats strobe, then R7 reload
        step(1, 16'h1234, 1, 0);
        chk("R11 cleared", tot_energy, 0);
        chk("R11 vld dropped", res_vld, 0);
        step(1, 16'h0F0F, 0, 0);
        chk("R7 after clear load only", res_vld, 0);
        step(1, 16'h0F0E, 0, 0);
        chk("R11 word after clear reference", res_flips, 1);

        // R9 saturation
        gnd_wgt = 8'hFF; side_wgt = 8'hFF;
        for (int k = 0; k < 8; k++) step(1, (k % 2) ? 16'h5555 : 16'hAAAA, 0, 0);
        chk("R9 saturated energy", tot_energy, TOT_MAX);
        step(1, 16'h5555, 0, 0);
        chk("R9 stays saturated", tot_energy, TOT_MAX);
        step(0, 0, 0, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule